// File: doc/BRIEF.md
# Strobe-Driven FIFO with Rewind and Half-Occupancy Flag

This block is a first-in first-out buffer of `DEPTH` words of `WIDTH` bits (512 x 9 by default). Words leave in the same order they entered. Writers and readers request transfers with active-low strobe pulses rather than a clocked handshake. Both strobes pass through two-stage synchronisers into the block clock. Each detected high-to-low transition performs exactly one transfer.

Three active-low status outputs report the occupancy: full, empty and half-occupied. An active-low rewind input returns the read position to the first location while both strobes are idle. Data already stored can then be read out again. Read data is qualified by an output-enable that models a bus released whenever the read strobe is high. An active-low master reset returns everything to the empty state.

The strobes are a pulse protocol, so no valid/ready pair is used at the edge. A writer must not rely on a write landing while `full_n` is low. A reader must not rely on a read while `empty_n` is low. Each pulse should stay low and then high for at least three clocks each.

Top module: `rtf_fifo`

## Requirements
- R1: Words are returned in the order they were written, and `DEPTH` words of `WIDTH` bits can be held at once.
- R2: A falling edge on `wr_n` stores `din` and raises the occupancy by one, three clock edges after the fall. Holding `wr_n` low performs exactly one write.
- R3: A falling edge on `rd_n` loads the oldest word onto `dout` three clock edges after the fall and lowers the occupancy by one. `dout_oe` is 1 from that same edge while `rd_n` stays low.
- R4: `empty_n` is 0 exactly when the occupancy is 0. A read requested while empty changes neither `dout` nor the occupancy.
- R5: `full_n` is 0 exactly when the occupancy is `DEPTH`. A write requested while full is discarded, and the stored words and occupancy stay unchanged.
- R6: `half_n` is 0 exactly when the occupancy is `DEPTH/2` or more.
- R7: `rt_n` low, while both strobes are high, moves the read position to location 0 and sets the occupancy to the number of words written since reset (no wrap). All flags follow the new occupancy. Later reads start from the first word written.
- R8: While and after `rst_n` is low: `empty_n`=0, `full_n`=1, `half_n`=1, `dout_oe`=0 and `dout`=0.
- R9: A write and a read detected in the same cycle both take effect, judged on the occupancy before that cycle. When empty, only the write happens. When full, only the read happens.
- R10: `dout_oe` returns to 0 within three clock edges after `rd_n` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Master reset, active low |
| wr_n | input | 1 | Write strobe, active low, acts on falling edge |
| rd_n | input | 1 | Read strobe, active low, acts on falling edge |
| rt_n | input | 1 | Rewind request, active low |
| din | input | WIDTH | Write data |
| dout | output | WIDTH | Read data |
| dout_oe | output | 1 | Read data enable, 1 while the read strobe is held low |
| full_n | output | 1 | Full flag, active low |
| empty_n | output | 1 | Empty flag, active low |
| half_n | output | 1 | Half-occupied flag, active low |

## Verification
The bench builds the block with `DEPTH`=8 and `WIDTH`=9. With that depth, every occupancy from 0 to full, and the half threshold at 4, falls inside one sweep of single-word operations. Every flag transition is checked against a counter kept in the bench. The small depth also makes overflow and underflow attempts cheap. So are a rewind after a partial drain and simultaneous read/write at both the empty and the full boundary.

// File: rtl/rtf_pkg.sv
package rtf_pkg;

  typedef struct packed {
    logic full_n;
    logic empty_n;
    logic half_n;
  } rtf_flags_t;

  function automatic rtf_flags_t rtf_flags(input int unsigned occ, input int unsigned depth);
    rtf_flags_t f;
    f.full_n  = (occ != depth);
    f.empty_n = (occ != 0);
    f.half_n  = (occ < depth / 2);
    return f;
  endfunction

endpackage

// File: rtl/rtf_strobe_sync.sv
module rtf_strobe_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe_n,
  output logic level_n,
  output logic fall
);
  logic [STAGES-1:0] chain;
  logic              prev;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[0] <= 1'b1;
          else        chain[0] <= strobe_n;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[g] <= 1'b1;
          else        chain[g] <= chain[g-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) prev <= 1'b1;
    else        prev <= chain[STAGES-1];

  assign level_n = chain[STAGES-1];
  assign fall    = prev & ~chain[STAGES-1];
endmodule

// File: rtl/rtf_ctrl.sv
module rtf_ctrl #(
  parameter int DEPTH = 512,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_fall,
  input  logic          rd_fall,
  input  logic          rt_req,
  output logic          wr_en,
  output logic          rd_en,
  output logic [AW-1:0] wr_addr,
  output logic [AW-1:0] rd_addr,
  output logic [CW-1:0] occ
);
  assign wr_en = wr_fall && (occ != CW'(DEPTH));
  assign rd_en = rd_fall && (occ != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_addr <= '0;
      rd_addr <= '0;
      occ     <= '0;
    end else if (rt_req) begin
      rd_addr <= '0;
      occ     <= CW'(wr_addr);
    end else begin
      if (wr_en) wr_addr <= wr_addr + AW'(1);
      if (rd_en) rd_addr <= rd_addr + AW'(1);
      case ({wr_en, rd_en})
        2'b10:   occ <= occ + CW'(1);
        2'b01:   occ <= occ - CW'(1);
        default: occ <= occ;
      endcase
    end
  end
endmodule

// File: rtl/rtf_store.sv
module rtf_store #(
  parameter int DEPTH = 512,
  parameter int WIDTH = 9,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_en,
  input  logic [AW-1:0]    rd_addr,
  output logic [WIDTH-1:0] rd_data
);
  logic [WIDTH-1:0] cells [DEPTH];

  always_ff @(posedge clk)
    if (wr_en) cells[wr_addr] <= wr_data;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)     rd_data <= '0;
    else if (rd_en) rd_data <= cells[rd_addr];
endmodule

// File: rtl/rtf_fifo.sv
module rtf_fifo #(
  parameter int DEPTH = 512,
  parameter int WIDTH = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_n,
  input  logic             rd_n,
  input  logic             rt_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout,
  output logic             dout_oe,
  output logic             full_n,
  output logic             empty_n,
  output logic             half_n
);
  import rtf_pkg::*;
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic          wr_lvl_n, rd_lvl_n, rt_lvl_n;
  logic          wr_fall, rd_fall, rt_fall_unused;
  logic          rt_req, wr_en, rd_en;
  logic [AW-1:0] wr_addr, rd_addr;
  logic [CW-1:0] occ;
  rtf_flags_t    flags;

  rtf_strobe_sync u_wr_sync (.clk, .rst_n, .strobe_n(wr_n), .level_n(wr_lvl_n), .fall(wr_fall));
  rtf_strobe_sync u_rd_sync (.clk, .rst_n, .strobe_n(rd_n), .level_n(rd_lvl_n), .fall(rd_fall));
  rtf_strobe_sync u_rt_sync (.clk, .rst_n, .strobe_n(rt_n), .level_n(rt_lvl_n), .fall(rt_fall_unused));

  assign rt_req = !rt_lvl_n && wr_lvl_n && rd_lvl_n;

  rtf_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk, .rst_n, .wr_fall, .rd_fall, .rt_req,
    .wr_en, .rd_en, .wr_addr, .rd_addr, .occ
  );

  rtf_store #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_store (
    .clk, .rst_n, .wr_en, .wr_addr, .wr_data(din),
    .rd_en, .rd_addr, .rd_data(dout)
  );

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) dout_oe <= 1'b0;
    else        dout_oe <= ~rd_lvl_n;

  assign flags   = rtf_flags(32'(occ), DEPTH);
  assign full_n  = flags.full_n;
  assign empty_n = flags.empty_n;
  assign half_n  = flags.half_n;
endmodule

// File: rtl/rtf_fifo_chk.sv
module rtf_fifo_chk #(
  parameter int DEPTH = 512,
  parameter int WIDTH = 9,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_fall,
  input logic             rd_fall,
  input logic             rt_req,
  input logic [CW-1:0]    occ,
  input logic [WIDTH-1:0] dout,
  input logic             dout_oe,
  input logic             full_n,
  input logic             empty_n,
  input logic             half_n
);
  p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!full_n && wr_fall && !rd_fall && !rt_req) |=> !full_n);

  p_no_underflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!empty_n && rd_fall && !wr_fall && !rt_req) |=> (!empty_n && $stable(dout)));

  p_flags_exclusive_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(!full_n && !empty_n));

  p_half_implies_nonempty_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !half_n |-> empty_n);

  p_dout_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_fall |=> $stable(dout));

  p_occ_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!rt_req && !wr_fall && !rd_fall) |=> $stable(occ));

  p_occ_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= CW'(DEPTH));
endmodule

bind rtf_fifo rtf_fifo_chk #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_fall(wr_fall), .rd_fall(rd_fall), .rt_req(rt_req),
  .occ(occ), .dout(dout), .dout_oe(dout_oe), .full_n(full_n), .empty_n(empty_n), .half_n(half_n)
);

// File: tb/rtf_fifo_test.sv
module rtf_fifo_test;
  localparam int DEPTH = 8;
  localparam int WIDTH = 9;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             wr_n = 1'b1, rd_n = 1'b1, rt_n = 1'b1;
  logic [WIDTH-1:0] din = '0;
  logic [WIDTH-1:0] dout;
  logic             dout_oe, full_n, empty_n, half_n;

  int checks = 0, failures = 0;
  int m_cnt = 0, m_wp = 0, m_rp = 0, m_written = 0;
  int m_dout = 0;
  int m_mem [DEPTH];

  always #4 clk = ~clk;

  rtf_fifo #(.DEPTH(DEPTH), .WIDTH(WIDTH)) uut (
    .clk, .rst_n, .wr_n, .rd_n, .rt_n, .din, .dout, .dout_oe, .full_n, .empty_n, .half_n
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic check_flags(input string req);
    check({req, " empty_n"}, int'(empty_n), int'(m_cnt != 0));
    check({req, " full_n"},  int'(full_n),  int'(m_cnt != DEPTH));
    check({req, " half_n"},  int'(half_n),  int'(m_cnt < DEPTH / 2));
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; wr_n = 1'b1; rd_n = 1'b1; rt_n = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    m_cnt = 0; m_wp = 0; m_rp = 0; m_written = 0; m_dout = 0;
  endtask

  // One strobe pulse pair: w/r request, d is write data
  task automatic op(input bit w, input bit r, input int d, input string req);
    bit can_w, can_r;
    can_w = (m_cnt < DEPTH);
    can_r = (m_cnt > 0);
    if (w && can_w) begin
      m_mem[m_wp] = d; m_wp = (m_wp + 1) % DEPTH; m_written++;
    end
    if (r && can_r) begin
      m_dout = m_mem[m_rp]; m_rp = (m_rp + 1) % DEPTH;
    end
    m_cnt = m_cnt + ((w && can_w) ? 1 : 0) - ((r && can_r) ? 1 : 0);
    @(negedge clk);
    din = WIDTH'(d); wr_n = !w; rd_n = !r;
    repeat (4) @(negedge clk);
    if (r) begin
      check({req, " R3 oe while low"}, int'(dout_oe), 1);
      check({req, " R1 dout"}, int'(dout), m_dout);
    end
    wr_n = 1'b1; rd_n = 1'b1;
    repeat (4) @(negedge clk);
    check({req, " R10 oe released"}, int'(dout_oe), 0);
    check_flags(req);
  endtask

  function automatic int pat(input int i);
    return (i * 37 + 11) % (1 << WIDTH);
  endfunction

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        failures++; checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  initial begin
    do_reset();
    // R8 reset state
    check("R8 empty_n", int'(empty_n), 0);
    check("R8 full_n", int'(full_n), 1);
    check("R8 half_n", int'(half_n), 1);
    check("R8 dout_oe", int'(dout_oe), 0);
    check("R8 dout", int'(dout), 0);

    // R2 R6 fill sweep, flags at every occupancy
    for (int i = 0; i < DEPTH; i++) op(1, 0, pat(i), "R2 R6 fill");
    // R5 writes while full are dropped
    op(1, 0, 9'h1AA, "R5 overflow");
    op(1, 0, 9'h155, "R5 overflow");
    // R9 simultaneous at full: read only
    op(1, 1, 9'h0F0, "R9 full both");
    // R1 R3 drain sweep in order
    while (m_cnt > 0) op(0, 1, 0, "R1 R3 drain");
    // R4 read while empty: dout unchanged
    op(0, 1, 0, "R4 underflow");
    op(0, 1, 0, "R4 underflow");

    // R7 rewind after partial drain
    do_reset();
    for (int i = 0; i < 6; i++) op(1, 0, pat(i + 20), "R7 load");
    for (int i = 0; i < 3; i++) op(0, 1, 0, "R7 partial read");
    @(negedge clk); rt_n = 1'b0;
    repeat (4) @(negedge clk); rt_n = 1'b1;
    repeat (4) @(negedge clk);
    m_rp = 0; m_cnt = m_written;
    check_flags("R7 rewind flags");
    for (int i = 0; i < 6; i++) op(0, 1, 0, "R7 replay");

    // R2 long hold writes once
    do_reset();
    @(negedge clk); din = 9'h077; wr_n = 1'b0;
    repeat (12) @(negedge clk); wr_n = 1'b1;
    repeat (4) @(negedge clk);
    m_mem[0] = 9'h077; m_wp = 1; m_cnt = 1; m_written = 1;
    check_flags("R2 single per fall");
    op(0, 1, 0, "R2 hold readback");
    check("R2 hold empty after one read", int'(empty_n), 0);

    // R9 simultaneous on empty: write only; then mid-occupancy both
    do_reset();
    op(1, 1, 9'h123, "R9 empty both");
    check("R9 empty both dout", int'(dout), 0);
    op(1, 0, 9'h045, "R9 load");
    op(1, 1, 9'h0AB, "R9 mid both");
    while (m_cnt > 0) op(0, 1, 0, "R9 drain");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule